// File: doc/BRIEF.md
# Pin-Change and External Interrupt Flags

This block watches one dedicated external interrupt pin and a group of six general-purpose pins. It keeps one sticky flag for the external pin and one shared flag for the whole pin group. Every pin is first passed through a two-flop synchronizer. An event is found by comparing the current synchronized level with the level seen one cycle earlier. A two-bit sense selection decides which activity on the external pin counts as an event. A six-bit mask decides which group pins can raise the shared flag.

Each flag drives an interrupt request toward the CPU. The request only passes when the global interrupt enable and that source's own enable are both high. A flag is cleared in two ways: when the CPU acknowledges the matching vector, or when software writes a one to the flag's bit. If a new event and a clear arrive in the same cycle, the event wins. When the external pin is in level-sense mode, its flag is held at zero. In that mode the request follows the synchronized pin level directly.

Top module: `pin_irq_flags`

## Requirements
- R1: After reset both flags and both interrupt requests are 0, and the mask read-back is 8'h3F.
- R2: The external pin sense code is 01 for any change, 10 for a falling edge and 11 for a rising edge. In each of these modes `extFlag` sets only on the selected kind of edge.
- R3: With sense code 00 (low level), `extFlag` is forced to 0 and stays 0. `extIrq` equals globalEnable AND extEnable AND NOT the synchronized pin level.
- R4: `pcFlag` sets when any group pin whose mask bit is 1 changes level. A change on a pin whose mask bit is 0 leaves the flag unchanged.
- R5: `extIrq` (in the edge modes) and `pcIrq` are high only when the flag is 1, `globalEnable` is 1 and the source enable is 1.
- R6: A one-cycle pulse on `ackExt` or `ackPc` clears the matching flag at the next clock edge.
- R7: A write with `wrAddr`=0 clears `extFlag` where `wrData` bit 0 is 1, and clears `pcFlag` where bit 1 is 1. A zero in either bit leaves that flag unchanged.
- R8: When a set event and a clear (write or acknowledge) hit the same flag in the same cycle, the flag ends up 1.
- R9: A write with `wrAddr`=1 loads `wrData[5:0]` into the mask. Read-back bits 7 and 6 are always 0. Writes to address 0 leave the mask unchanged.
- R10: A pin change applied before clock edge E1 is visible on the flag after edge E3, and not after edge E2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extPinAsync | input | 1 | External interrupt pin, not yet synchronized |
| gpPinAsync | input | 6 | General-purpose pin group, not yet synchronized |
| senseMode | input | 2 | External pin sense code (00 low, 01 any, 10 fall, 11 rise) |
| extEnable | input | 1 | External source enable |
| pcEnable | input | 1 | Pin-group source enable |
| globalEnable | input | 1 | Global interrupt enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 = flag clear register, 1 = mask register |
| wrData | input | 8 | Write data |
| ackExt | input | 1 | Vector acknowledge for the external source |
| ackPc | input | 1 | Vector acknowledge for the pin group |
| extFlag | output | 1 | External pin flag |
| pcFlag | output | 1 | Pin-group flag |
| extIrq | output | 1 | External interrupt request |
| pcIrq | output | 1 | Pin-group interrupt request |
| maskRead | output | 8 | Mask register read-back |

## Verification
Two things can land on the same flag in the same clock cycle: a detected event and a clear, where the clear comes from a one written by software or from a vector acknowledge. The bench counts the synchronizer and edge registers so that the clear strobe is driven in the exact cycle in which the detected event is present. It then checks that the flag reads 1 afterwards. It repeats this for the pin-group flag with a write and for the external flag with an acknowledge. A plain clear applied in a quiet cycle must then bring each flag back to 0.

// File: rtl/pif_pkg.sv
package pif_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_e;

  typedef struct packed {
    logic extSet;
    logic extClr;
    logic pcSet;
    logic pcClr;
    logic maskWr;
    logic levelMode;
  } pifStrobes_t;

  localparam logic ADDR_FLAGS = 1'b0;
  localparam logic ADDR_MASK  = 1'b1;
  localparam int   EXT_BIT    = 0;
  localparam int   PC_BIT     = 1;

endpackage

// File: rtl/pif_datapath.sv
module pif_datapath
  import pif_pkg::*;
#(
  parameter int PIN_COUNT   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 extPinAsync,
  input  logic [PIN_COUNT-1:0] gpPinAsync,
  input  pifStrobes_t          strb,
  input  logic [PIN_COUNT-1:0] maskData,
  output logic                 extCur,
  output logic                 extPrev,
  output logic [PIN_COUNT-1:0] gpCur,
  output logic [PIN_COUNT-1:0] gpPrev,
  output logic [PIN_COUNT-1:0] maskQ,
  output logic                 extFlag,
  output logic                 pcFlag
);

  localparam int LANES = PIN_COUNT + 1;

  // Synchronizer chain: the external pin sits in the top lane.
  logic [LANES-1:0] syncStage [SYNC_STAGES];
  logic [LANES-1:0] prevQ;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    if (s == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncStage[s] <= '0;
        else       syncStage[s] <= {extPinAsync, gpPinAsync};
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncStage[s] <= '0;
        else       syncStage[s] <= syncStage[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncStage[SYNC_STAGES-1];
  end

  assign extCur  = syncStage[SYNC_STAGES-1][PIN_COUNT];
  assign gpCur   = syncStage[SYNC_STAGES-1][PIN_COUNT-1:0];
  assign extPrev = prevQ[PIN_COUNT];
  assign gpPrev  = prevQ[PIN_COUNT-1:0];

  // Mask register: all pins enabled out of reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '1;
    else if (strb.maskWr) maskQ <= maskData;
  end

  // Flags: a set beats a clear; level mode holds the external flag low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extFlag <= 1'b0;
      pcFlag  <= 1'b0;
    end else begin
      if (strb.levelMode)   extFlag <= 1'b0;
      else if (strb.extSet) extFlag <= 1'b1;
      else if (strb.extClr) extFlag <= 1'b0;

      if (strb.pcSet)       pcFlag <= 1'b1;
      else if (strb.pcClr)  pcFlag <= 1'b0;
    end
  end

  // R3
  level_holds_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.levelMode |=> !extFlag);

  // R8
  pc_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pcSet |=> pcFlag);

  // R8
  ext_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.extSet && !strb.levelMode) |=> extFlag);

  // R7
  pc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pcClr && !strb.pcSet) |=> !pcFlag);

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.maskWr |=> $stable(maskQ));

endmodule

// File: rtl/pif_ctrl.sv
module pif_ctrl
  import pif_pkg::*;
#(
  parameter int PIN_COUNT = 6
) (
  input  logic                 extCur,
  input  logic                 extPrev,
  input  logic [PIN_COUNT-1:0] gpCur,
  input  logic [PIN_COUNT-1:0] gpPrev,
  input  logic [PIN_COUNT-1:0] maskQ,
  input  logic [1:0]           senseMode,
  input  logic                 wrEn,
  input  logic                 wrAddr,
  input  logic [1:0]           clrBits,
  input  logic                 ackExt,
  input  logic                 ackPc,
  output pifStrobes_t          strb
);

  logic extRise, extFall, extEvent, flagWr;

  assign extRise = extCur & ~extPrev;
  assign extFall = ~extCur & extPrev;

  always_comb begin
    unique case (senseMode_e'(senseMode))
      SENSE_ANY:  extEvent = extRise | extFall;
      SENSE_FALL: extEvent = extFall;
      SENSE_RISE: extEvent = extRise;
      default:    extEvent = 1'b0;
    endcase
  end

  assign flagWr = wrEn && (wrAddr == ADDR_FLAGS);

  always_comb begin
    strb.levelMode = (senseMode_e'(senseMode) == SENSE_LOW);
    strb.extSet    = extEvent;
    strb.extClr    = ackExt | (flagWr & clrBits[EXT_BIT]);
    strb.pcSet     = |((gpCur ^ gpPrev) & maskQ);
    strb.pcClr     = ackPc | (flagWr & clrBits[PC_BIT]);
    strb.maskWr    = wrEn && (wrAddr == ADDR_MASK);
  end

endmodule

// File: rtl/pin_irq_flags.sv
module pin_irq_flags
  import pif_pkg::*;
#(
  parameter int PIN_COUNT   = 6,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 extPinAsync,
  input  logic [PIN_COUNT-1:0] gpPinAsync,
  input  logic [1:0]           senseMode,
  input  logic                 extEnable,
  input  logic                 pcEnable,
  input  logic                 globalEnable,
  input  logic                 wrEn,
  input  logic                 wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 ackExt,
  input  logic                 ackPc,
  output logic                 extFlag,
  output logic                 pcFlag,
  output logic                 extIrq,
  output logic                 pcIrq,
  output logic [DATA_W-1:0]    maskRead
);

  localparam int PAD_W = DATA_W - PIN_COUNT;

  pifStrobes_t          strb;
  logic                 extCur, extPrev;
  logic [PIN_COUNT-1:0] gpCur, gpPrev, maskQ;

  pif_ctrl #(.PIN_COUNT(PIN_COUNT)) u_ctrl (
    .extCur    (extCur),
    .extPrev   (extPrev),
    .gpCur     (gpCur),
    .gpPrev    (gpPrev),
    .maskQ     (maskQ),
    .senseMode (senseMode),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .clrBits   (wrData[1:0]),
    .ackExt    (ackExt),
    .ackPc     (ackPc),
    .strb      (strb)
  );

  pif_datapath #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .extPinAsync (extPinAsync),
    .gpPinAsync  (gpPinAsync),
    .strb        (strb),
    .maskData    (wrData[PIN_COUNT-1:0]),
    .extCur      (extCur),
    .extPrev     (extPrev),
    .gpCur       (gpCur),
    .gpPrev      (gpPrev),
    .maskQ       (maskQ),
    .extFlag     (extFlag),
    .pcFlag      (pcFlag)
  );

  if (PAD_W > 0) begin : gPad
    logic unusedWrBits;
    assign unusedWrBits = ^wrData[DATA_W-1:PIN_COUNT];
    assign maskRead = {{PAD_W{1'b0}}, maskQ};
  end else begin : gNoPad
    assign maskRead = maskQ[DATA_W-1:0];
  end

  assign extIrq = globalEnable & extEnable & (strb.levelMode ? ~extCur : extFlag);
  assign pcIrq  = globalEnable & pcEnable & pcFlag;

  // R5
  pc_irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcIrq |-> (globalEnable && pcEnable && pcFlag));

  // R5
  ext_irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    extIrq |-> (globalEnable && extEnable));

endmodule

// File: tb/pin_irq_flags_bench.sv
module pin_irq_flags_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extPinAsync = 1'b0;
  logic [5:0] gpPinAsync = '0;
  logic [1:0] senseMode = 2'b00;
  logic       extEnable = 1'b0, pcEnable = 1'b0, globalEnable = 1'b0;
  logic       wrEn = 1'b0, wrAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic       ackExt = 1'b0, ackPc = 1'b0;
  logic       extFlag, pcFlag, extIrq, pcIrq;
  logic [7:0] maskRead;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_flags u_pin_irq_flags (
    .clk(clk), .rstN(rstN), .extPinAsync(extPinAsync), .gpPinAsync(gpPinAsync),
    .senseMode(senseMode), .extEnable(extEnable), .pcEnable(pcEnable),
    .globalEnable(globalEnable), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ackExt(ackExt), .ackPc(ackPc), .extFlag(extFlag), .pcFlag(pcFlag),
    .extIrq(extIrq), .pcIrq(pcIrq), .maskRead(maskRead)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearFlags(input logic [7:0] bits);
    wrEn = 1'b1; wrAddr = 1'b0; wrData = bits;
    tick(1);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic writeMask(input logic [7:0] val);
    wrEn = 1'b1; wrAddr = 1'b1; wrData = val;
    tick(1);
    wrEn = 1'b0; wrAddr = 1'b0; wrData = '0;
  endtask

  task automatic testReset;
    check("R1 extFlag", {7'b0, extFlag}, 8'h00);
    check("R1 pcFlag", {7'b0, pcFlag}, 8'h00);
    check("R1 irqs", {6'b0, extIrq, pcIrq}, 8'h00);
    check("R1 maskRead", maskRead, 8'h3F);
  endtask

  task automatic testSense;
    senseMode = 2'b11; tick(1);
    extPinAsync = 1'b1; tick(3);
    check("R2 rise sets in rise mode", {7'b0, extFlag}, 8'h01);
    clearFlags(8'h01);
    extPinAsync = 1'b0; tick(4);
    check("R2 fall ignored in rise mode", {7'b0, extFlag}, 8'h00);
    senseMode = 2'b10; tick(1);
    extPinAsync = 1'b1; tick(4);
    check("R2 rise ignored in fall mode", {7'b0, extFlag}, 8'h00);
    extPinAsync = 1'b0; tick(3);
    check("R2 fall sets in fall mode", {7'b0, extFlag}, 8'h01);
    clearFlags(8'h01);
    senseMode = 2'b01; tick(1);
    extPinAsync = 1'b1; tick(3);
    check("R2 rise sets in any mode", {7'b0, extFlag}, 8'h01);
    clearFlags(8'h01);
    check("R7 bit0 clears extFlag", {7'b0, extFlag}, 8'h00);
    extPinAsync = 1'b0; tick(3);
    check("R2 fall sets in any mode", {7'b0, extFlag}, 8'h01);
    clearFlags(8'h01);
  endtask

  task automatic testLatency;
    gpPinAsync[0] = ~gpPinAsync[0];
    tick(2);
    check("R10 not after E2", {7'b0, pcFlag}, 8'h00);
    tick(1);
    check("R10 set after E3", {7'b0, pcFlag}, 8'h01);
    clearFlags(8'h02);
    check("R7 bit1 clears pcFlag", {7'b0, pcFlag}, 8'h00);
  endtask

  task automatic testPinChange;
    gpPinAsync[3] = ~gpPinAsync[3]; tick(4);
    check("R4 unmasked pin sets", {7'b0, pcFlag}, 8'h01);
    clearFlags(8'h02);
    writeMask(8'h3E);
    gpPinAsync[0] = ~gpPinAsync[0]; tick(4);
    check("R4 masked pin ignored", {7'b0, pcFlag}, 8'h00);
    gpPinAsync[5] = ~gpPinAsync[5]; tick(4);
    check("R4 other pin still sets", {7'b0, pcFlag}, 8'h01);
    clearFlags(8'h02);
    writeMask(8'h3F);
  endtask

  task automatic testMask;
    writeMask(8'hFF);
    check("R9 reserved bits read zero", maskRead, 8'h3F);
    writeMask(8'hC5);
    check("R9 mask loads low bits", maskRead, 8'h05);
    clearFlags(8'hFF);
    check("R9 flag write leaves mask", maskRead, 8'h05);
    writeMask(8'h3F);
    check("R9 mask restored", maskRead, 8'h3F);
  endtask

  task automatic testGateAndAck;
    gpPinAsync[2] = ~gpPinAsync[2]; tick(4);
    globalEnable = 1'b0; pcEnable = 1'b1; tick(1);
    check("R5 global off blocks pcIrq", {7'b0, pcIrq}, 8'h00);
    globalEnable = 1'b1; pcEnable = 1'b0; tick(1);
    check("R5 source off blocks pcIrq", {7'b0, pcIrq}, 8'h00);
    pcEnable = 1'b1; tick(1);
    check("R5 pcIrq passes", {7'b0, pcIrq}, 8'h01);
    clearFlags(8'h01);
    check("R7 zero bit leaves pcFlag", {7'b0, pcFlag}, 8'h01);
    ackPc = 1'b1; tick(1); ackPc = 1'b0;
    check("R6 ackPc clears", {7'b0, pcFlag}, 8'h00);
    check("R5 pcIrq drops", {7'b0, pcIrq}, 8'h00);
    senseMode = 2'b11; extEnable = 1'b1; tick(1);
    extPinAsync = 1'b1; tick(3);
    check("R5 extIrq passes", {7'b0, extIrq}, 8'h01);
    ackExt = 1'b1; tick(1); ackExt = 1'b0;
    check("R6 ackExt clears", {7'b0, extFlag}, 8'h00);
    check("R5 extIrq drops", {7'b0, extIrq}, 8'h00);
  endtask

  task automatic testSetWins;
    gpPinAsync[1] = ~gpPinAsync[1];
    tick(2);
    wrEn = 1'b1; wrAddr = 1'b0; wrData = 8'h02;
    tick(1);
    wrEn = 1'b0; wrData = '0;
    check("R8 set beats write clear", {7'b0, pcFlag}, 8'h01);
    clearFlags(8'h02);
    check("R8 later clear works", {7'b0, pcFlag}, 8'h00);
    extPinAsync = 1'b0; tick(4);
    extPinAsync = 1'b1;
    tick(2);
    ackExt = 1'b1;
    tick(1);
    ackExt = 1'b0;
    check("R8 set beats ack", {7'b0, extFlag}, 8'h01);
  endtask

  task automatic testLevel;
    senseMode = 2'b00; tick(1);
    check("R3 flag forced low", {7'b0, extFlag}, 8'h00);
    check("R3 no request while high", {7'b0, extIrq}, 8'h00);
    extPinAsync = 1'b0; tick(3);
    check("R3 request while low", {7'b0, extIrq}, 8'h01);
    check("R3 flag stays low", {7'b0, extFlag}, 8'h00);
    globalEnable = 1'b0; tick(1);
    check("R3 global gates level request", {7'b0, extIrq}, 8'h00);
    globalEnable = 1'b1;
    extPinAsync = 1'b1; tick(3);
    check("R3 request ends when high", {7'b0, extIrq}, 8'h00);
  endtask

  initial begin
    tick(2);
    rstN = 1'b1;
    tick(1);
    testReset();
    testSense();
    testLatency();
    testPinChange();
    testMask();
    testGateAndAck();
    testSetWins();
    testLevel();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule